// File: doc/BRIEF.md
# Programmable Chip-Select Decoder with Boot Remap

This block turns a 32-bit request address into one of five active-low select strobes: a boot flash region, an internal SRAM region and a set of general-purpose regions (three by default). Each region is placed by a configuration word that software writes through a simple register write port. The word holds a page-granular base, a block-size code and, for the regions other than flash, an enable bit. The decode compares the upper address bits (31:12) against the base with a block-size mask. Because it is a masked match, software must place every base on a multiple of its block size.

After reset the flash region is a 2 Mbyte window at address zero, so the processor can fetch its boot code. A remap control bit decides whether flash also shows up as an alias at address zero once it has been moved elsewhere. Clearing the remap bit keeps the alias. Setting it frees address zero for RAM. Requests in the top quarter of the address space, and requests that hit no enabled region, raise a no-hit flag instead of a strobe. Outputs are registered: a request presented before a clock edge is reflected on the strobes just after that edge.

Top module: `csel_decoder`

## Requirements
- R1: After reset, the flash region is based at 0x0 with block-size code 9 (2 Mbytes), the remap bit is 0, the SRAM and general-purpose regions are disabled, all strobes are high and no_hit is low.
- R2: Strobes and no_hit are registered: they show the decode of the request sampled at the previous rising clock edge. When req_valid was low, all strobes are high and no_hit is low.
- R3: A region covers 4 Kbytes shifted left by its block-size code (bits 3:0 of its word); codes above 14 act as 14 (64 Mbytes).
- R4: A region's base is bits 23:4 of its word; with the low block-size bits masked off on both sides, it is compared with request address bits 31:12.
- R5: While the remap bit is 0, the flash strobe also goes low for requests inside a window of the flash block size at address 0x0.
- R6: While the remap bit is 1, the flash strobe goes low only inside the window at its programmed base.
- R7: Bit 31 enables the SRAM and general-purpose regions; a disabled region never drives its strobe low. Flash ignores bit 31 and is always enabled.
- R8: When windows overlap, a fixed priority decides which strobe goes low: flash, then SRAM, then general-purpose 0, 1 and 2. At most one strobe is low at a time.
- R9: A valid request with address bits 31:30 both set (0xC000_0000 and above) raises no_hit, and all strobes stay high, whatever the configuration.
- R10: A valid request that hits no enabled window raises no_hit, with all strobes high.
- R11: Write index 0 selects flash, 1 SRAM, 2 to 4 general-purpose 0 to 2, and 5 the remap word (bit 12 of the data). Writes to indexes 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_idx | input | 3 | Configuration word index |
| wr_data | input | 32 | Configuration write data |
| req_valid | input | 1 | Request address is valid |
| req_addr | input | 32 | Request byte address |
| flash_sel_n | output | 1 | Boot flash select, active low |
| sram_sel_n | output | 1 | Internal SRAM select, active low |
| gp_sel_n | output | 3 | General-purpose selects, active low, bit i for region i |
| no_hit | output | 1 | Valid request hit no enabled window or lay outside the decodable range |

## Verification
Directed requests probe the first and last byte of each window and the first byte past its end. Probing both block-size saturation and the fixed boundary at 0xC000_0000 separates a correct mask width from a mask that is off by one bit. Overlapping windows tell the priority order apart from a merge, and address-zero requests made before and after the remap bit is set tell the alias from the programmed base. Random configuration writes with size-aligned bases, and random addresses clustered around the programmed bases, are checked against a range-based reference model. They exercise the masked comparison over all block-size codes, the enable bits and the writes to unused indexes.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int PAGE_LSB  = 12;
  localparam int BASE_W    = 20;
  localparam int BSZ_W     = 4;
  localparam int BSZ_MAX   = 14;
  localparam int REMAP_BIT = 12;
  localparam int EN_BIT    = 31;
  localparam int BASE_LSB  = 4;

  typedef struct packed {
    logic              en;
    logic [BASE_W-1:0] base;
    logic [BSZ_W-1:0]  bsz;
  } region_cfg_t;
endpackage

// File: rtl/csel_cfg_regs.sv
module csel_cfg_regs
  import csel_pkg::*;
#(
  parameter int              NREG          = 5,
  parameter int              IDX_W         = 3,
  parameter logic [BSZ_W-1:0] FLASH_RST_BSZ = 4'd9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  output region_cfg_t      cfg [NREG],
  output logic             remap
);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    if (r == 0) begin : g_flash
      always_ff @(posedge clk) begin
        if (rst) begin
          cfg[r] <= '{en: 1'b1, base: '0, bsz: FLASH_RST_BSZ};
        end else if (wr_en && wr_idx == IDX_W'(r)) begin
          cfg[r] <= '{en: 1'b1,
                      base: wr_data[BASE_LSB +: BASE_W],
                      bsz: wr_data[BSZ_W-1:0]};
        end
      end
    end else begin : g_other
      always_ff @(posedge clk) begin
        if (rst) begin
          cfg[r] <= '0;
        end else if (wr_en && wr_idx == IDX_W'(r)) begin
          cfg[r] <= '{en: wr_data[EN_BIT],
                      base: wr_data[BASE_LSB +: BASE_W],
                      bsz: wr_data[BSZ_W-1:0]};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) remap <= 1'b0;
    else if (wr_en && wr_idx == IDX_W'(NREG)) remap <= wr_data[REMAP_BIT];
  end

  AST_RST_CFG: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg[0].bsz == FLASH_RST_BSZ && cfg[0].base == '0 &&
                    !remap && !cfg[1].en)); // R1

  AST_UNUSED_IDX: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx > IDX_W'(NREG)) |=>
      ($stable(remap) && $stable(cfg[0]) && $stable(cfg[NREG-1]))); // R11

endmodule

// File: rtl/csel_window_match.sv
module csel_window_match
  import csel_pkg::*;
(
  input  logic [BASE_W-1:0] page,
  input  region_cfg_t       cfg,
  input  logic              alias_en,
  output logic              hit
);

  logic [BSZ_W-1:0]  eff;
  logic [BASE_W-1:0] keep;
  logic              base_hit;
  logic              alias_hit;

  assign eff = (cfg.bsz > BSZ_W'(BSZ_MAX)) ? BSZ_W'(BSZ_MAX) : cfg.bsz;

  for (genvar b = 0; b < BASE_W; b++) begin : g_keep
    assign keep[b] = (b >= int'(eff));
  end

  assign base_hit  = cfg.en && (((page ^ cfg.base) & keep) == '0);
  assign alias_hit = alias_en && cfg.en && ((page & keep) == '0);
  assign hit       = base_hit || alias_hit;

endmodule

// File: rtl/csel_prio_out.sv
module csel_prio_out #(
  parameter int NREG = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            in_range,
  input  logic [NREG-1:0] hit,
  output logic [NREG-1:0] sel_n,
  output logic            no_hit
);

  logic [NREG-1:0] cand;
  logic [NREG-1:0] grant;

  assign cand  = (req_valid && in_range) ? hit : '0;
  assign grant = cand & (~cand + NREG'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_n  <= '1;
      no_hit <= 1'b0;
    end else begin
      sel_n  <= ~grant;
      no_hit <= req_valid && (grant == '0);
    end
  end

  AST_ONE_SEL: assert property (@(posedge clk) disable iff (rst)
    $countones(~sel_n) <= 1); // R8

  AST_TOP_PRIO: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_range && hit[0]) |=> !sel_n[0]); // R8

  AST_NOHIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    no_hit |-> (&sel_n)); // R10

  AST_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ((&sel_n) && !no_hit)); // R2

endmodule

// File: rtl/csel_decoder.sv
module csel_decoder
  import csel_pkg::*;
#(
  parameter int              NUM_GP        = 3,
  parameter logic [BSZ_W-1:0] FLASH_RST_BSZ = 4'd9,
  localparam int             NREG          = NUM_GP + 2,
  localparam int             IDX_W         = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_data,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  output logic              flash_sel_n,
  output logic              sram_sel_n,
  output logic [NUM_GP-1:0] gp_sel_n,
  output logic              no_hit
);

  region_cfg_t       cfg [NREG];
  logic              remap;
  logic [NREG-1:0]   hit;
  logic [NREG-1:0]   sel_n;
  logic              in_range;
  logic [BASE_W-1:0] page;

  assign page     = req_addr[31:PAGE_LSB];
  assign in_range = (req_addr[31:30] != 2'b11);

  csel_cfg_regs #(
    .NREG(NREG), .IDX_W(IDX_W), .FLASH_RST_BSZ(FLASH_RST_BSZ)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .cfg(cfg), .remap(remap)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_win
    logic alias_en;
    if (r == 0) begin : g_alias
      assign alias_en = !remap;
    end else begin : g_noalias
      assign alias_en = 1'b0;
    end
    csel_window_match u_match (
      .page(page), .cfg(cfg[r]), .alias_en(alias_en), .hit(hit[r])
    );
  end

  csel_prio_out #(.NREG(NREG)) u_prio (
    .clk(clk), .rst(rst), .req_valid(req_valid), .in_range(in_range),
    .hit(hit), .sel_n(sel_n), .no_hit(no_hit)
  );

  assign flash_sel_n = sel_n[0];
  assign sram_sel_n  = sel_n[1];
  assign gp_sel_n    = sel_n[NREG-1:2];

  AST_HIGH_RANGE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr[31:30] == 2'b11) |=> (no_hit && flash_sel_n)); // R9

  AST_RST_OUT: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&sel_n && !no_hit)); // R1

endmodule

// File: tb/tb_csel_decoder.sv
module tb_csel_decoder;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        flash_sel_n, sram_sel_n, no_hit;
  logic [2:0]  gp_sel_n;

  int checks = 0;
  int fails  = 0;

  logic        m_en   [5];
  logic [19:0] m_base [5];
  logic [3:0]  m_bsz  [5];
  logic        m_remap;

  always #(CLK_PERIOD/2) clk = ~clk;

  csel_decoder dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .req_valid(req_valid), .req_addr(req_addr), .flash_sel_n(flash_sel_n),
    .sram_sel_n(sram_sel_n), .gp_sel_n(gp_sel_n), .no_hit(no_hit)
  );

  function automatic logic [63:0] win_size(input logic [3:0] bsz);
    return 64'h1000 << ((bsz > 4'd14) ? 4'd14 : bsz);
  endfunction

  function automatic logic in_win(input int r, input logic [31:0] a);
    logic [63:0] lo, sz;
    lo = {32'h0, m_base[r], 12'h000};
    sz = win_size(m_bsz[r]);
    if (!m_en[r]) return 1'b0;
    if ({32'h0, a} >= lo && {32'h0, a} < lo + sz) return 1'b1;
    if (r == 0 && !m_remap && {32'h0, a} < sz) return 1'b1;
    return 1'b0;
  endfunction

  // {no_hit, gp2, gp1, gp0, sram, flash}
  function automatic logic [5:0] expect_out(input logic [31:0] a);
    if (a >= 32'hC000_0000) return 6'b111111;
    for (int r = 0; r < 5; r++) begin
      if (in_win(r, a)) begin
        logic [5:0] v;
        v = 6'b011111;
        v[r] = 1'b0;
        return v;
      end
    end
    return 6'b111111;
  endfunction

  task automatic check(input string req, input logic [5:0] exp);
    logic [5:0] got;
    got = {no_hit, gp_sel_n, sram_sel_n, flash_sel_n};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: addr=%h got=%b expected=%b", req, req_addr, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx < 3'd5) begin
      m_en[idx]   = (idx == 3'd0) ? 1'b1 : d[31];
      m_base[idx] = d[23:4];
      m_bsz[idx]  = d[3:0];
    end else if (idx == 3'd5) begin
      m_remap = d[12];
    end
  endtask

  function automatic logic [31:0] word(input logic en, input logic [19:0] base,
                                        input logic [3:0] bsz);
    return {en, 7'h0, base, bsz};
  endfunction

  task automatic req(input logic [31:0] a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    check(tag, expect_out(a));
  endtask

  initial begin
    m_en[0] = 1'b1; m_base[0] = '0; m_bsz[0] = 4'd9; m_remap = 1'b0;
    for (int r = 1; r < 5; r++) begin
      m_en[r] = 1'b0; m_base[r] = '0; m_bsz[r] = '0;
    end
    void'($urandom(32'd6021));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R1 reset outputs", 6'b011111);

    req(32'h0000_0000, "R1 flash at zero");
    req(32'h001F_FFFF, "R3 flash last byte");
    req(32'h0020_0000, "R10 past flash window");
    @(negedge clk) req_valid = 1'b0;
    @(negedge clk);
    check("R2 idle", 6'b011111);

    wr(3'd0, word(1'b0, 20'h10000, 4'd9));
    req(32'h1000_0004, "R4 flash at base");
    req(32'h0000_0100, "R5 alias at zero");
    wr(3'd5, 32'h0000_1000);
    req(32'h0000_0100, "R6 alias removed");
    req(32'h101F_FFFF, "R6 flash base kept");

    wr(3'd1, word(1'b1, 20'h10000, 4'd4));
    req(32'h1000_0000, "R8 flash over sram");
    wr(3'd2, word(1'b1, 20'h20000, 4'd15));
    req(32'h2000_0000, "R3 gp0 start");
    req(32'h23FF_FFFF, "R3 gp0 saturated end");
    req(32'h2400_0000, "R3 past saturated window");
    wr(3'd3, word(1'b1, 20'h20000, 4'd2));
    req(32'h2000_1000, "R8 gp0 over gp1");
    wr(3'd4, word(1'b0, 20'h30000, 4'd2));
    req(32'h3000_0000, "R7 disabled gp2");
    wr(3'd4, word(1'b1, 20'hC0000, 4'd12));
    req(32'hC000_0000, "R9 top range");
    req(32'hFFFF_FFFF, "R9 top range end");
    wr(3'd1, word(1'b1, 20'h50000, 4'd0));
    req(32'h5000_0FFF, "R4 sram 4K end");
    req(32'h5000_1000, "R10 past sram");
    @(negedge clk); wr_en = 1'b1; wr_idx = 3'd6; wr_data = 32'hFFFF_FFFF;
    @(negedge clk); wr_idx = 3'd7;
    @(negedge clk); wr_en = 1'b0;
    req(32'h0000_0100, "R11 idx6/7 remap unchanged");
    req(32'h2000_0000, "R11 idx6/7 gp0 unchanged");

    for (int i = 0; i < 600; i++) begin
      if ($urandom % 4 == 0) begin
        int unsigned r;
        logic [3:0]  bsz;
        logic [19:0] base;
        logic [19:0] msk;
        r = $urandom % 6;
        if (r == 5) begin
          wr(3'd5, ($urandom % 2) << 12);
        end else begin
          bsz  = 4'($urandom);
          msk  = ~((20'h1 << ((bsz > 4'd14) ? 4'd14 : bsz)) - 20'h1);
          base = 20'($urandom) & msk;
          wr(3'(r), word(1'($urandom), base, bsz));
        end
      end
      if ($urandom % 4 == 0) begin
        req($urandom, "R4 random addr");
      end else begin
        int unsigned r;
        logic [63:0] sz;
        logic [31:0] a;
        r  = $urandom % 5;
        sz = win_size(m_bsz[r]);
        a  = {m_base[r], 12'h000} + 32'($urandom % (2 * sz));
        if ($urandom % 8 == 0) a = 32'($urandom % (2 * sz));
        req(a, "R8 random near base");
      end
      if ($urandom % 16 == 0) begin
        @(negedge clk) req_valid = 1'b0;
        @(negedge clk);
        check("R2 random idle", 6'b011111);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule